// File: doc/BRIEF.md
# Per-Lane Integer Vector ALU

This block is the integer and bitwise datapath for a single lane of a 64-lane vector unit. Every cycle it takes two 32-bit operands, a 5-bit operation code, the lane's own index and a 64-bit lane mask. One clock later it presents a 32-bit result and an updated copy of the lane mask. The result and the mask come from one output register stage, so downstream logic sees both in the same cycle.

Most operations act on the two operands alone: shifts, minimum and maximum, bit counting, field masks and 24-bit multiplies. Three groups also use the lane index. The carry-producing add writes its carry into the mask bit at this lane's index. The select reads that same mask bit. The masked counts tally only the operand bits that belong to lanes numbered below this one. Every operation that does not produce a carry passes the mask through unchanged, so a set of lane instances can share one mask word.

Top module: `lane_int_alu`

## Requirements
- R1: While `rst_n` is low, `result` and `mask_out` are zero. After reset, the outputs show the operation whose inputs were present at the previous rising clock edge.
- R2: Opcode 0 shifts `opa` left by `opb[4:0]`. Opcode 1 shifts `opa` right logically and opcode 2 shifts it right arithmetically, both by `opb[4:0]`.
- R3: Opcodes 3, 4 and 5 are the left, logical-right and arithmetic-right shifts with the operand roles swapped: `opb` is shifted by `opa[4:0]`.
- R4: Opcodes 6 and 7 return the signed minimum and the signed maximum of `opa` and `opb`. Opcodes 8 and 9 return the unsigned minimum and the unsigned maximum.
- R5: Opcode 10 returns `opb` plus the number of set bits in `opa`. Opcode 11 returns ((1 << opa[4:0]) - 1) << opb[4:0], computed modulo 2^32.
- R6: Opcode 12 returns `opb` plus the number of set bits i in `opa` with i < `lane_id`. In lanes 32 and up, all 32 bits count.
- R7: Opcode 13 returns `opb` plus the number of set bits i in `opa` with i + 32 < `lane_id`. In lanes 0 to 32 it returns `opb` unchanged.
- R8: Opcodes 14 to 17 multiply the low 24 bits of each operand. Opcodes 14 and 15 sign-extend the operands and opcodes 16 and 17 zero-extend them. Opcodes 14 and 16 return product bits 31:0. Opcode 15 returns the product arithmetically shifted right by 32, and opcode 17 returns it logically shifted right by 32.
- R9: Opcode 18 returns the low 32 bits of `opa` + `opb`. It writes the carry out into `mask_out[lane_id]` and copies every other mask bit from `mask_in`.
- R10: Opcode 19 returns `opb` when `mask_in[lane_id]` is set and `opa` when it is clear.
- R11: Every opcode other than 18 copies `mask_in` to `mask_out` unchanged. Opcodes 20 to 31 return a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 5 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| lane_id | input | 6 | Index of this lane within the vector |
| mask_in | input | 64 | Lane mask before the operation |
| result | output | 32 | Registered result |
| mask_out | output | 64 | Registered lane mask after the operation |

## Verification
The operand table places values at the sign bit and at all-ones patterns. With these values the signed and unsigned comparisons give different answers, and arithmetic and logical shifts give different answers. Shift amounts above 31 and operand bits above bit 23 are included; they show whether the block truncates or ignores them as R2, R3 and R8 require.

Both masked counts are swept over all 64 lane indices with a sparse operand and with an all-ones operand. The sweep exposes off-by-one errors at lane 0, at lane 32 and at lane 63, where the lower count saturates and the upper count starts.

For the carry add and the select, the mask patterns have neighbouring bits that differ from the lane's own bit. A write or read at the wrong index therefore changes the observed result or mask.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_SHL       = 5'd0,
        OP_SHR       = 5'd1,
        OP_SAR       = 5'd2,
        OP_SHL_R     = 5'd3,
        OP_SHR_R     = 5'd4,
        OP_SAR_R     = 5'd5,
        OP_MIN_S     = 5'd6,
        OP_MAX_S     = 5'd7,
        OP_MIN_U     = 5'd8,
        OP_MAX_U     = 5'd9,
        OP_POPC      = 5'd10,
        OP_FMASK     = 5'd11,
        OP_LCNT_LO   = 5'd12,
        OP_LCNT_HI   = 5'd13,
        OP_MUL_LO_S  = 5'd14,
        OP_MUL_HI_S  = 5'd15,
        OP_MUL_LO_U  = 5'd16,
        OP_MUL_HI_U  = 5'd17,
        OP_ADD_C     = 5'd18,
        OP_SELECT    = 5'd19
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_LOGIC = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

endpackage

// File: rtl/lane_shifter.sv
module lane_shifter
    import lane_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  shift_kind_e    kind,
    input  logic           reverse,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int SH_W = $clog2(W);

    logic [W-1:0]    val;
    logic [SH_W-1:0] amt;

    // Reversed forms swap which operand supplies the data and which the amount.
    always_comb begin
        val = reverse ? b : a;
        amt = reverse ? a[SH_W-1:0] : b[SH_W-1:0];
        case (kind)
            SH_LEFT:  y = val << amt;
            SH_LOGIC: y = val >> amt;
            default:  y = W'($signed(val) >>> amt);
        endcase
    end

endmodule

// File: rtl/lane_bitcount.sv
module lane_bitcount #(
    parameter int W      = 32,
    parameter int LANE_W = 6
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [LANE_W-1:0] lane,
    output logic [W-1:0]      popc_y,
    output logic [W-1:0]      fmask_y,
    output logic [W-1:0]      lcnt_lo_y,
    output logic [W-1:0]      lcnt_hi_y
);
    localparam int LANES = 1 << LANE_W;
    localparam int SH_W  = $clog2(W);
    localparam int CNT_W = $clog2(W + 1);

    logic [LANES-1:0] below;
    logic [W-1:0]     lo_sel;
    logic [W-1:0]     hi_sel;

    function automatic logic [CNT_W-1:0] ones(input logic [W-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < W; i++) begin
            n = n + CNT_W'(v[i]);
        end
        return n;
    endfunction

    // Bits set for every lane numbered strictly below this one.
    always_comb begin
        below  = (LANES'(1) << lane) - LANES'(1);
        lo_sel = a & below[W-1:0];
        hi_sel = a & below[2*W-1:W];
    end

    always_comb begin
        popc_y    = b + W'(ones(a));
        lcnt_lo_y = b + W'(ones(lo_sel));
        lcnt_hi_y = b + W'(ones(hi_sel));
        fmask_y   = ((W'(1) << a[SH_W-1:0]) - W'(1)) << b[SH_W-1:0];
    end

endmodule

// File: rtl/lane_mul24.sv
module lane_mul24 #(
    parameter int W  = 32,
    parameter int MW = 24
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    input  logic         take_high,
    output logic [W-1:0] y
);
    localparam int PW  = 2 * MW;
    localparam int EXT = 2 * W - PW;

    logic [PW-1:0] ea;
    logic [PW-1:0] eb;
    logic [PW-1:0] prod;
    logic          fill;

    always_comb begin
        ea   = {{(PW-MW){is_signed & a[MW-1]}}, a[MW-1:0]};
        eb   = {{(PW-MW){is_signed & b[MW-1]}}, b[MW-1:0]};
        prod = ea * eb;
        fill = is_signed & prod[PW-1];
        y    = take_high ? {{EXT{fill}}, prod[PW-1:W]} : prod[W-1:0];
    end

endmodule

// File: rtl/lane_int_alu.sv
module lane_int_alu
    import lane_alu_pkg::*;
#(
    parameter int W      = 32,
    parameter int LANE_W = 6,
    parameter int MUL_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              op,
    input  logic [W-1:0]            opa,
    input  logic [W-1:0]            opb,
    input  logic [LANE_W-1:0]       lane_id,
    input  logic [(1<<LANE_W)-1:0]  mask_in,
    output logic [W-1:0]            result,
    output logic [(1<<LANE_W)-1:0]  mask_out
);
    localparam int LANES = 1 << LANE_W;

    typedef struct packed {
        logic [W-1:0]     res;
        logic [LANES-1:0] mask;
        logic             armed;
    } alu_state_t;

    alu_state_t  st_d, st_q;
    alu_op_e     op_e;
    shift_kind_e sh_kind;
    logic        sh_rev;
    logic        mul_signed, mul_high;
    logic [W-1:0] sh_y, popc_y, fmask_y, lcnt_lo_y, lcnt_hi_y, mul_y;
    logic [W:0]   sum;

    always_comb begin
        op_e = alu_op_e'(op);
        case (op_e)
            OP_SHR, OP_SHR_R: sh_kind = SH_LOGIC;
            OP_SAR, OP_SAR_R: sh_kind = SH_ARITH;
            default:          sh_kind = SH_LEFT;
        endcase
        sh_rev     = (op_e == OP_SHL_R) || (op_e == OP_SHR_R) || (op_e == OP_SAR_R);
        mul_signed = (op_e == OP_MUL_LO_S) || (op_e == OP_MUL_HI_S);
        mul_high   = (op_e == OP_MUL_HI_S) || (op_e == OP_MUL_HI_U);
    end

    lane_shifter #(.W(W)) u_shift (
        .kind(sh_kind), .reverse(sh_rev), .a(opa), .b(opb), .y(sh_y)
    );

    lane_bitcount #(.W(W), .LANE_W(LANE_W)) u_count (
        .a(opa), .b(opb), .lane(lane_id),
        .popc_y(popc_y), .fmask_y(fmask_y),
        .lcnt_lo_y(lcnt_lo_y), .lcnt_hi_y(lcnt_hi_y)
    );

    lane_mul24 #(.W(W), .MW(MUL_W)) u_mul (
        .a(opa), .b(opb), .is_signed(mul_signed), .take_high(mul_high), .y(mul_y)
    );

    always_comb begin
        sum        = {1'b0, opa} + {1'b0, opb};
        st_d       = st_q;
        st_d.armed = 1'b1;
        st_d.mask  = mask_in;
        case (op_e)
            OP_SHL, OP_SHR, OP_SAR,
            OP_SHL_R, OP_SHR_R, OP_SAR_R: st_d.res = sh_y;
            OP_MIN_S:    st_d.res = ($signed(opa) < $signed(opb)) ? opa : opb;
            OP_MAX_S:    st_d.res = ($signed(opa) > $signed(opb)) ? opa : opb;
            OP_MIN_U:    st_d.res = (opa < opb) ? opa : opb;
            OP_MAX_U:    st_d.res = (opa > opb) ? opa : opb;
            OP_POPC:     st_d.res = popc_y;
            OP_FMASK:    st_d.res = fmask_y;
            OP_LCNT_LO:  st_d.res = lcnt_lo_y;
            OP_LCNT_HI:  st_d.res = lcnt_hi_y;
            OP_MUL_LO_S, OP_MUL_HI_S,
            OP_MUL_LO_U, OP_MUL_HI_U: st_d.res = mul_y;
            OP_ADD_C: begin
                st_d.res           = sum[W-1:0];
                st_d.mask[lane_id] = sum[W];
            end
            OP_SELECT:   st_d.res = mask_in[lane_id] ? opb : opa;
            default:     st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result   = st_q.res;
    assign mask_out = st_q.mask;

    // R11
    mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && $past(op) != 5'd18) |-> (mask_out == $past(mask_in)));

    // R9
    carry_lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && $past(op) == 5'd18) |->
        (((mask_out ^ $past(mask_in)) & ~(LANES'(1) << $past(lane_id))) == '0));

    // R10
    select_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && $past(op) == 5'd19) |->
        (result == (((($past(mask_in) >> $past(lane_id)) & LANES'(1)) != '0)
                    ? $past(opb) : $past(opa))));

    // R4
    max_u_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && $past(op) == 5'd9) |->
        (result >= $past(opa) && result >= $past(opb)));

    // R8
    mul_hi_u_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && $past(op) == 5'd17) |-> (result[W-1:2*MUL_W-W] == '0));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        (!rst_n) |-> (result == '0 && mask_out == '0));

endmodule

// File: tb/sim_lane_int_alu.sv
module sim_lane_int_alu;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [5:0]  lane_id = '0;
    logic [63:0] mask_in = '0;
    logic [31:0] result;
    logic [63:0] mask_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_int_alu u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
        .lane_id(lane_id), .mask_in(mask_in), .result(result), .mask_out(mask_out)
    );

    // {op, opa, opb, expected result}; lane 0, mask zero
    localparam logic [100:0] VECS [NV] = '{
        {5'd0,  32'h00000001, 32'h00000024, 32'h00000010},
        {5'd1,  32'h80000000, 32'h0000001F, 32'h00000001},
        {5'd2,  32'h80000000, 32'h00000004, 32'hF8000000},
        {5'd3,  32'h00000021, 32'h40000001, 32'h80000002},
        {5'd4,  32'h00000008, 32'hFF000000, 32'h00FF0000},
        {5'd5,  32'h00000008, 32'h80000000, 32'hFF800000},
        {5'd6,  32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF},
        {5'd7,  32'hFFFFFFFF, 32'h00000001, 32'h00000001},
        {5'd8,  32'hFFFFFFFF, 32'h00000001, 32'h00000001},
        {5'd9,  32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF},
        {5'd10, 32'hF0F0F0F0, 32'h00000005, 32'h00000015},
        {5'd11, 32'h00000004, 32'h00000008, 32'h00000F00},
        {5'd11, 32'h00000020, 32'h00000003, 32'h00000000},
        {5'd11, 32'h0000001F, 32'h00000001, 32'hFFFFFFFE},
        {5'd14, 32'hABFFFFFF, 32'h00000003, 32'hFFFFFFFD},
        {5'd15, 32'h00800000, 32'h00800000, 32'h00004000},
        {5'd15, 32'h00800000, 32'h007FFFFF, 32'hFFFFC000},
        {5'd16, 32'h00FFFFFF, 32'h00FFFFFF, 32'hFE000001},
        {5'd17, 32'h00FFFFFF, 32'hFFFFFFFF, 32'h0000FFFF},
        {5'd18, 32'hFFFFFFFF, 32'h00000002, 32'h00000001},
        {5'd20, 32'h12345678, 32'h00000009, 32'h00000000},
        {5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}
    };

    function automatic string req_of(input logic [4:0] o);
        if (o <= 5'd2)  return "R2";
        if (o <= 5'd5)  return "R3";
        if (o <= 5'd9)  return "R4";
        if (o <= 5'd11) return "R5";
        if (o <= 5'd17 && o >= 5'd14) return "R8";
        if (o == 5'd18) return "R9";
        return "R11";
    endfunction

    task automatic chk32(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s result got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk64(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s mask got %h expected %h", req, got, exp);
        end
    endtask

    // Drive on a falling edge; the result is registered at the next rising edge
    // and read at the falling edge after it.
    task automatic run_op(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [5:0] ln, input logic [63:0] m);
        @(negedge clk);
        op = o; opa = a; opb = b; lane_id = ln; mask_in = m;
        @(negedge clk);
    endtask

    function automatic logic [31:0] below_count(input logic [31:0] a, input logic [31:0] b,
                                                input int lane, input int base);
        logic [31:0] c;
        c = b;
        for (int i = 0; i < 32; i++) begin
            if (a[i] && (i + base) < lane) c = c + 32'd1;
        end
        return c;
    endfunction

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero during reset despite active inputs
        op = 5'd18; opa = 32'hFFFFFFFF; opb = 32'h1; lane_id = 6'd3; mask_in = '1;
        repeat (3) @(negedge clk);
        chk32("R1", result, 32'h0);
        chk64("R1", mask_out, 64'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            run_op(VECS[k][100:96], VECS[k][95:64], VECS[k][63:32], 6'd0, 64'h0);
            chk32(req_of(VECS[k][100:96]), result, VECS[k][31:0]);
        end

        // R1: one-cycle latency, back-to-back change visible next cycle
        run_op(5'd19, 32'hAAAA0000, 32'h0000BBBB, 6'd0, 64'h0);
        chk32("R1", result, 32'hAAAA0000);

        // R6 / R7: sweep every lane
        for (int ln = 0; ln < 64; ln++) begin
            run_op(5'd12, 32'hA5A55A5A, 32'h00000100, 6'(ln), 64'h0);
            chk32("R6", result, below_count(32'hA5A55A5A, 32'h100, ln, 0));
            run_op(5'd13, 32'hA5A55A5A, 32'h00000100, 6'(ln), 64'h0);
            chk32("R7", result, below_count(32'hA5A55A5A, 32'h100, ln, 32));
            run_op(5'd12, 32'hFFFFFFFF, 32'h0, 6'(ln), 64'h0);
            chk32("R6", result, below_count(32'hFFFFFFFF, 32'h0, ln, 0));
            run_op(5'd13, 32'hFFFFFFFF, 32'h0, 6'(ln), 64'h0);
            chk32("R7", result, below_count(32'hFFFFFFFF, 32'h0, ln, 32));
        end

        // R9: carry into own lane bit only
        run_op(5'd18, 32'hFFFFFFFF, 32'h1, 6'd37, 64'h5555555555555555);
        chk32("R9", result, 32'h0);
        chk64("R9", mask_out, 64'h5555555555555555 | (64'd1 << 37));
        run_op(5'd18, 32'h1, 32'h2, 6'd0, 64'h5555555555555555);
        chk32("R9", result, 32'h3);
        chk64("R9", mask_out, 64'h5555555555555554);
        run_op(5'd18, 32'h0, 32'h0, 6'd63, 64'hFFFFFFFFFFFFFFFF);
        chk64("R9", mask_out, 64'h7FFFFFFFFFFFFFFF);

        // R10: select by own lane bit
        run_op(5'd19, 32'h11111111, 32'h22222222, 6'd5, 64'h20);
        chk32("R10", result, 32'h22222222);
        run_op(5'd19, 32'h11111111, 32'h22222222, 6'd5, ~64'h20);
        chk32("R10", result, 32'h11111111);
        run_op(5'd19, 32'h11111111, 32'h22222222, 6'd63, 64'h8000000000000000);
        chk32("R10", result, 32'h22222222);

        // R11: mask passes through non-carry operations
        run_op(5'd0, 32'h1, 32'h1, 6'd9, 64'hDEADBEEF01234567);
        chk64("R11", mask_out, 64'hDEADBEEF01234567);
        run_op(5'd9, 32'h5, 32'h7, 6'd40, 64'h0F0F0F0F0F0F0F0F);
        chk64("R11", mask_out, 64'h0F0F0F0F0F0F0F0F);
        chk32("R4", result, 32'h7);
        run_op(5'd25, 32'hFFFF, 32'hFFFF, 6'd12, 64'h123456789ABCDEF0);
        chk64("R11", mask_out, 64'h123456789ABCDEF0);
        chk32("R11", result, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule